// File: doc/BRIEF.md
# Page-Loaded Differential Look-Up-Table Array

This block is a small array of programmable logic cells. Each cell is a 4-input, 1-output look-up table. Its 16 truth-table bits are not shifted in one at a time. The whole array's configuration is taken in a single clock edge from a page of sample pairs. Each table bit is resolved differentially: the two digitised intensity samples of its pair are compared.

A load request starts an integration timer, which models the detector exposure time. When the programmed number of cycles has elapsed, all table bits of all cells are captured together and a one-cycle done pulse follows. During the integration the cells keep answering from their previous contents, and further requests are ignored. Between loads each cell maps its 4-bit select input to its output combinationally.

Top module: `lutcfg_array`

## Requirements
- R1: Each cell's output is combinationally equal to its stored table bit indexed by its 4-bit select value (`lut_out[b] = table_b[sel_b]`).
- R2: The array holds N_COLS x N_ROWS = 2 x 3 = 6 cells of 16 entries. Cell b uses `lut_sel[b*4 +: 4]`. Its entry e uses samples `samp_a/samp_b[(b*16+e)*SAMP_W +: SAMP_W]`.
- R3: A captured table bit is 1 only when its first sample is strictly greater than its second (unsigned). Equal or smaller gives 0.
- R4: A load request accepted while idle causes capture exactly N rising edges after the accepting edge, where N = `integ_cycles` and 0 is treated as 1. All 96 bits are taken on that same edge from the samples present at it.
- R5: `done` is high for exactly the one cycle following the capture edge and low otherwise.
- R6: `busy` is high from the cycle after the accepting edge through the capture edge, and low otherwise.
- R7: During an integration every cell keeps answering from its previously captured contents.
- R8: A load request arriving while `busy` is high is ignored: it neither restarts nor extends the integration.
- R9: After synchronous reset every table holds zeros, and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_req | input | 1 | Request a page load |
| integ_cycles | input | CNT_W | Integration length in cycles (0 acts as 1) |
| samp_a | input | 96*SAMP_W | First sample of every table-bit pair |
| samp_b | input | 96*SAMP_W | Second sample of every table-bit pair |
| lut_sel | input | 6*4 | Select inputs of all cells |
| lut_out | output | 6 | Outputs of all cells |
| busy | output | 1 | Integration in progress |
| done | output | 1 | One-cycle pulse after capture |

## Verification
The bench builds the block with its defaults: 2 x 3 cells, 8-bit samples and an 8-bit integration counter. Integration lengths from 0 to about 20 cycles cover the zero-as-one rule and the single-cycle case, as well as longer windows in which repeated requests are tried. The 8-bit samples make exact ties and extreme pairs easy to force, alongside random pages whose samples change on every integration cycle, so only the values present at the capture edge decide the table.

// File: rtl/lutcfg_pkg.sv
package lutcfg_pkg;
    localparam int LUT_IN  = 4;
    localparam int ENTRIES = 1 << LUT_IN;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_INTEG = 1'b1
    } ctrl_state_e;

    // Differential decision of one table bit: strict unsigned compare.
    function automatic logic sense_bit(input logic [15:0] a, input logic [15:0] b);
        return (a > b);
    endfunction
endpackage

// File: rtl/pair_sense.sv
module pair_sense
    import lutcfg_pkg::*;
#(
    parameter int SAMP_W = 8
) (
    input  logic [ENTRIES*SAMP_W-1:0] pa,
    input  logic [ENTRIES*SAMP_W-1:0] pb,
    output logic [ENTRIES-1:0]        bits
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_pair
        logic [15:0] va, vb;
        always_comb begin
            va = 16'(pa[e*SAMP_W +: SAMP_W]);
            vb = 16'(pb[e*SAMP_W +: SAMP_W]);
            bits[e] = sense_bit(va, vb);
        end
    end
endmodule

// File: rtl/integ_ctrl.sv
module integ_ctrl
    import lutcfg_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_req,
    input  logic [CNT_W-1:0] integ_cycles,
    output logic             busy,
    output logic             done,
    output logic             capture
);
    ctrl_state_e      state;
    logic [CNT_W-1:0] remain;
    logic [CNT_W-1:0] start_val;

    always_comb begin
        start_val = (integ_cycles == '0) ? CNT_W'(1) : integ_cycles;
        busy      = (state == ST_INTEG);
        capture   = busy && (remain == CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            remain <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (load_req) begin
                        state  <= ST_INTEG;
                        remain <= start_val;
                    end
                end
                ST_INTEG: begin
                    if (remain == CNT_W'(1)) begin
                        state  <= ST_IDLE;
                        remain <= '0;
                        done   <= 1'b1;
                    end else begin
                        remain <= remain - CNT_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
    import lutcfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ENTRIES-1:0] new_bits,
    input  logic [LUT_IN-1:0] sel,
    output logic [ENTRIES-1:0] table_q,
    output logic              y
);
    always_ff @(posedge clk) begin
        if (rst)
            table_q <= '0;
        else if (capture)
            table_q <= new_bits;
    end

    assign y = table_q[sel];
endmodule

// File: rtl/lutcfg_array.sv
module lutcfg_array
    import lutcfg_pkg::*;
#(
    parameter int N_COLS = 2,
    parameter int N_ROWS = 3,
    parameter int SAMP_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    load_req,
    input  logic [CNT_W-1:0]                        integ_cycles,
    input  logic [N_COLS*N_ROWS*ENTRIES*SAMP_W-1:0] samp_a,
    input  logic [N_COLS*N_ROWS*ENTRIES*SAMP_W-1:0] samp_b,
    input  logic [N_COLS*N_ROWS*LUT_IN-1:0]         lut_sel,
    output logic [N_COLS*N_ROWS-1:0]                lut_out,
    output logic                                    busy,
    output logic                                    done
);
    localparam int N_BLK = N_COLS * N_ROWS;
    localparam int TAB_W = N_BLK * ENTRIES;
    localparam int PG_W  = ENTRIES * SAMP_W;

    logic             capture;
    logic [TAB_W-1:0] cfg_bits;

    integ_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .load_req     (load_req),
        .integ_cycles (integ_cycles),
        .busy         (busy),
        .done         (done),
        .capture      (capture)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        for (genvar c = 0; c < N_COLS; c++) begin : g_col
            localparam int B = r * N_COLS + c;
            logic [ENTRIES-1:0] sensed;

            pair_sense #(.SAMP_W(SAMP_W)) u_sense (
                .pa   (samp_a[B*PG_W +: PG_W]),
                .pb   (samp_b[B*PG_W +: PG_W]),
                .bits (sensed)
            );

            lut_cell u_cell (
                .clk      (clk),
                .rst      (rst),
                .capture  (capture),
                .new_bits (sensed),
                .sel      (lut_sel[B*LUT_IN +: LUT_IN]),
                .table_q  (cfg_bits[B*ENTRIES +: ENTRIES]),
                .y        (lut_out[B])
            );
        end
    end
endmodule

// File: rtl/lutcfg_chk.sv
module lutcfg_chk #(
    parameter int TAB_W = 96
) (
    input logic             clk,
    input logic             rst,
    input logic             load_req,
    input logic             busy,
    input logic             done,
    input logic [TAB_W-1:0] cfg_bits
);
    // R5: done follows the last busy cycle and is a single pulse
    p_done_after_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));
    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R6: busy only starts from a request
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(load_req));
    // R6/R8: a request during busy never ends busy without done
    p_ignore_req_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && load_req) |=> (busy || done));
    // R7: tables change only on the capture edge
    p_table_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(cfg_bits));
endmodule

bind lutcfg_array lutcfg_chk #(.TAB_W(TAB_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_req (load_req),
    .busy     (busy),
    .done     (done),
    .cfg_bits (cfg_bits)
);

// File: tb/test_lutcfg_array.sv
module test_lutcfg_array;
    localparam int NB  = 6;
    localparam int ENT = 16;
    localparam int SW  = 8;
    localparam int CW  = 8;
    localparam int NP  = NB * ENT;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              load_req = 1'b0;
    logic [CW-1:0]     integ_cycles = '0;
    logic [NP*SW-1:0]  samp_a = '0;
    logic [NP*SW-1:0]  samp_b = '0;
    logic [NB*4-1:0]   lut_sel = '0;
    logic [NB-1:0]     lut_out;
    logic              busy, done;

    int total = 0;
    int bad   = 0;
    logic [NP-1:0] exp_tab = '0;

    always #4 clk = ~clk;

    lutcfg_array i_lutcfg_array (
        .clk(clk), .rst(rst), .load_req(load_req), .integ_cycles(integ_cycles),
        .samp_a(samp_a), .samp_b(samp_b), .lut_sel(lut_sel),
        .lut_out(lut_out), .busy(busy), .done(done)
    );

    function automatic logic [NP-1:0] page_of(input logic [NP*SW-1:0] a, input logic [NP*SW-1:0] b);
        logic [NP-1:0] t;
        for (int i = 0; i < NP; i++)
            t[i] = (a[i*SW +: SW] > b[i*SW +: SW]);
        return t;
    endfunction

    function automatic logic [NB-1:0] lookup(input logic [NP-1:0] t, input logic [NB*4-1:0] s);
        logic [NB-1:0] y;
        for (int b = 0; b < NB; b++)
            y[b] = t[b*ENT + int'(s[b*4 +: 4])];
        return y;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // mode 0 random, 1 ties on even entries, 2 all ties, 3 all a>b
    task automatic fill(input int mode);
        for (int i = 0; i < NP; i++) begin
            logic [SW-1:0] x, y;
            x = SW'($urandom);
            y = SW'($urandom);
            if (mode == 1 && (i % 2 == 0)) y = x;
            if (mode == 2) y = x;
            if (mode == 3) begin x = 8'hFF; y = 8'h00; end
            samp_a[i*SW +: SW] = x;
            samp_b[i*SW +: SW] = y;
        end
    endtask

    task automatic sweep(input string req);
        for (int s = 0; s < 16; s++) begin
            for (int b = 0; b < NB; b++)
                lut_sel[b*4 +: 4] = 4'((s + 3*b) % 16);
            #1;
            check(req, 32'(lut_out), 32'(lookup(exp_tab, lut_sel)));
        end
    endtask

    task automatic do_load(input int n, input int mode, input bit retrig);
        int neff;
        neff = (n == 0) ? 1 : n;
        @(negedge clk);
        integ_cycles = CW'(n);
        load_req = 1'b1;
        fill(mode);
        @(posedge clk);
        for (int k = 1; k <= neff; k++) begin
            @(negedge clk);
            load_req = 1'b0;
            check("R6 busy during integration", 32'(busy), 32'd1);
            check("R5 no done during integration", 32'(done), 32'd0);
            lut_sel = NB*4'($urandom);
            #1;
            check("R7 old contents during integration", 32'(lut_out), 32'(lookup(exp_tab, lut_sel)));
            fill(mode);
            if (retrig && (k == 2 || k == neff)) load_req = 1'b1;
            @(posedge clk);
        end
        exp_tab = page_of(samp_a, samp_b);
        @(negedge clk);
        load_req = 1'b0;
        fill(0);
        check("R5 done after capture", 32'(done), 32'd1);
        check("R6 busy cleared at capture", 32'(busy), 32'd0);
        sweep("R1 R3 R4 lookup of captured page");
        @(negedge clk);
        check("R5 done single cycle", 32'(done), 32'd0);
        check("R8 retrigger ignored, still idle", 32'(busy), 32'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R9 busy after reset", 32'(busy), 32'd0);
        check("R9 done after reset", 32'(done), 32'd0);
        sweep("R9 zero tables after reset");

        do_load(0, 0, 1'b0);   // R4 zero acts as one
        do_load(1, 3, 1'b0);   // R3 all ones, R2 full page
        do_load(5, 1, 1'b1);   // R3 ties, R8 retrigger
        do_load(2, 2, 1'b1);   // R3 all ties clear tables, R8 at last cycle
        do_load(12, 0, 1'b1);
        for (int t = 0; t < 12; t++)
            do_load(int'($urandom % 21), int'($urandom % 2), 1'(t % 2));

        // R4: exact capture edge, counted from acceptance
        @(negedge clk);
        integ_cycles = CW'(7);
        load_req = 1'b1;
        @(posedge clk);
        @(negedge clk);
        load_req = 1'b0;
        for (int k = 1; k < 7; k++) @(negedge clk);
        check("R4 busy on cycle before capture", 32'(busy), 32'd1);
        @(negedge clk);
        check("R4 done exactly N edges after accept", 32'(done), 32'd1);
        exp_tab = page_of(samp_a, samp_b);
        sweep("R2 page captured at edge N");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule